// File: doc/BRIEF.md
# Cacheable Bus Cycle Controller

This block runs one processor bus cycle at a time on behalf of the core. The core offers a request with four fields: a read/write flag, an address, a cacheable hint, and a flag that marks a write as the writeback of a modified line. When the block accepts the request it pulses the address strobe for one clock. On that same edge it drives the cacheability output: low means "cacheable read" on a read and "line writeback" on a write. It then counts ready strobes until the cycle ends.

The length of a read depends on two things: the block's own cacheability output and the external cache-enable input. That input is sampled on the first ready strobe, or on an earlier next-address strobe. Both must be asserted for a four-beat line burst; otherwise the read moves a single beat. A writeback always bursts, and the cache-enable input plays no part in it. The cacheability output keeps its level until next-address or the final ready strobe is seen.

The strobe, the cacheability line and the address are released when the system asserts backoff or when the block grants hold. The block does not drive high impedance itself; a single enable tells the pad ring to release them. A cycle cut off by backoff is replayed from its first clock with a fresh strobe once backoff goes away.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: On the edge that accepts a request, `cache_n` becomes 0 for a read with `req_cacheable`=1 or for a write with `req_dirty`=1, and 1 otherwise. `ads_n` goes low on that same edge.
- R2: `ads_n` is low for exactly one clock at the start of each cycle, and is 1 in every other clock.
- R3: A read ends after 4 `brdy_n`=0 beats when `cache_n`=0 and `ken_n` is sampled 0. Otherwise it ends after 1 beat.
- R4: A write with `cache_n`=0 (writeback) takes 4 beats and a write with `cache_n`=1 takes 1 beat, whatever the level of `ken_n`.
- R5: `ken_n` is sampled once, on the first edge of the cycle where `brdy_n`=0 or `na_n`=0. Later changes of `ken_n` do not change the beat count.
- R6: `cache_n` holds its level from the strobe edge until the edge where `na_n`=0 or the last expected `brdy_n`=0 is sampled. On that edge it returns to 1.
- R7: On the edge where `boff_n`=0 is sampled, `bus_oe` goes to 0, which releases `ads_n`, `cache_n` and `bus_addr`. A `brdy_n`=0 on that same edge is not counted and does not end the cycle.
- R8: On the edge where `boff_n`=1 is sampled after a backoff, an interrupted cycle restarts. `ads_n`=0 and `bus_oe`=1 are driven again, and `cache_n` takes the request's value. The beat count starts again from zero.
- R9: When `hold`=1 is sampled with no cycle active, `hlda` and `bus_oe`=0 follow on the next edge. They return to `hlda`=0 and `bus_oe`=1 on the edge where `hold`=0 is sampled.
- R10: `req_ready` is 1 only when no cycle is active, `hlda`=0, `hold`=0 and `boff_n`=1. If `hold` and `req_valid` arrive together, the hold is granted and no strobe is issued.
- R11: `cyc_done` is 1 for exactly one clock, starting on the edge that samples the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a cycle |
| req_ready | output | 1 | Offer is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Cycle address |
| req_cacheable | input | 1 | Core treats the read as cacheable |
| req_dirty | input | 1 | Write is a modified-line writeback |
| ads_n | output | 1 | Address strobe, active low |
| cache_n | output | 1 | Cacheability / writeback indication, active low |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_oe | output | 1 | 1 = pads drive ads_n, cache_n, bus_addr; 0 = released |
| ken_n | input | 1 | External cache enable, active low |
| brdy_n | input | 1 | Ready strobe for one beat, active low |
| na_n | input | 1 | Next-address request, active low |
| boff_n | input | 1 | Bus backoff, active low |
| hold | input | 1 | Bus hold request |
| hlda | output | 1 | Hold acknowledge |
| cyc_done | output | 1 | One-clock pulse at cycle end |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a backoff and a ready strobe. The bench drives `boff_n`=0 together with `brdy_n`=0 in the middle of a burst. It then checks three things: the pads are released, no completion appears, and after backoff lifts the replayed cycle needs all four beats again.

The second pair is a hold request and a core request. The bench raises `hold` in the same clock as `req_valid`. It requires `req_ready` to be low, `hlda` to rise on the next edge, and no address strobe to appear.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_DATA = 3'd2,
        ST_BOFF = 3'd3,
        ST_HELD = 3'd4
    } bcc_state_t;

    typedef struct packed {
        bcc_state_t state;
        logic       ads_n;
        logic       cache_n;
        logic       oe;
        logic       hlda;
        logic       done;
        logic       pend;
    } bcc_ctl_t;

endpackage

// File: rtl/bcc_req_reg.sv
module bcc_req_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cacheable_i,
    input  logic              dirty_i,
    output logic              want_now,
    output logic              wr_q,
    output logic              want_q,
    output logic [ADDR_W-1:0] addr_q
);

    logic              wr_d;
    logic              want_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        want_now = wr_i ? dirty_i : cacheable_i;
        wr_d     = wr_q;
        want_d   = want_q;
        addr_d   = addr_q;
        if (load) begin
            wr_d   = wr_i;
            want_d = want_now;
            addr_d = addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            want_q <= 1'b0;
            addr_q <= '0;
        end else begin
            wr_q   <= wr_d;
            want_q <= want_d;
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/bcc_beat_ctr.sv
module bcc_beat_ctr #(
    parameter int BURST_BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fix,
    input  logic fix_burst,
    input  logic beat,
    output logic fixed_q,
    output logic last
);

    localparam int CW = $clog2(BURST_BEATS + 1);
    localparam logic [CW-1:0] LONG = CW'(BURST_BEATS);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          burst_q, burst_d;
    logic          fixed_d;
    logic [CW-1:0] target;

    always_comb begin
        if (fixed_q) target = burst_q ? LONG : ONE;
        else         target = fix_burst ? LONG : ONE;
        last    = beat && ((cnt_q + ONE) == target);
        cnt_d   = cnt_q;
        burst_d = burst_q;
        fixed_d = fixed_q;
        if (clear) begin
            cnt_d   = '0;
            fixed_d = 1'b0;
            burst_d = 1'b0;
        end else begin
            if (fix && !fixed_q) begin
                fixed_d = 1'b1;
                burst_d = fix_burst;
            end
            if (beat) cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            burst_q <= 1'b0;
            fixed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            burst_q <= burst_d;
            fixed_q <= fixed_d;
        end
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
    import bcc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cacheable,
    input  logic              req_dirty,
    output logic              ads_n,
    output logic              cache_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_oe,
    input  logic              ken_n,
    input  logic              brdy_n,
    input  logic              na_n,
    input  logic              boff_n,
    input  logic              hold,
    output logic              hlda,
    output logic              cyc_done
);

    bcc_ctl_t ctl_q, ctl_d;

    logic load, want_now, wr_q, want_q;
    logic bc_clear, bc_fix, bc_beat, fix_burst, fixed_q, last;
    logic busy, in_data;

    bcc_req_reg #(.ADDR_W(ADDR_W)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .wr_i        (req_write),
        .addr_i      (req_addr),
        .cacheable_i (req_cacheable),
        .dirty_i     (req_dirty),
        .want_now    (want_now),
        .wr_q        (wr_q),
        .want_q      (want_q),
        .addr_q      (bus_addr)
    );

    bcc_beat_ctr #(.BURST_BEATS(BURST_BEATS)) u_beats (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (bc_clear),
        .fix       (bc_fix),
        .fix_burst (fix_burst),
        .beat      (bc_beat),
        .fixed_q   (fixed_q),
        .last      (last)
    );

    // writeback length ignores the cache-enable input
    assign fix_burst = wr_q ? want_q : (want_q && !ken_n);
    assign req_ready = (ctl_q.state == ST_IDLE) && !ctl_q.hlda && !hold && boff_n;
    assign busy      = (ctl_q.state == ST_ADDR) || (ctl_q.state == ST_DATA);
    assign in_data   = (ctl_q.state == ST_DATA);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ads_n = 1'b1;
        ctl_d.done  = 1'b0;
        load        = 1'b0;
        bc_clear    = 1'b0;
        bc_fix      = 1'b0;
        bc_beat     = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (!boff_n) begin
                    ctl_d.state = ST_BOFF;
                    ctl_d.oe    = 1'b0;
                    ctl_d.pend  = 1'b0;
                end else if (hold) begin
                    ctl_d.state = ST_HELD;
                    ctl_d.hlda  = 1'b1;
                    ctl_d.oe    = 1'b0;
                end else if (req_valid) begin
                    ctl_d.state   = ST_ADDR;
                    ctl_d.ads_n   = 1'b0;
                    ctl_d.cache_n = !want_now;
                    load          = 1'b1;
                    bc_clear      = 1'b1;
                end
            end
            ST_ADDR: begin
                if (!boff_n) begin
                    ctl_d.state = ST_BOFF;
                    ctl_d.oe    = 1'b0;
                    ctl_d.pend  = 1'b1;
                end else begin
                    ctl_d.state = ST_DATA;
                end
            end
            ST_DATA: begin
                if (!boff_n) begin
                    ctl_d.state = ST_BOFF;
                    ctl_d.oe    = 1'b0;
                    ctl_d.pend  = 1'b1;
                    bc_clear    = 1'b1;
                end else begin
                    bc_beat = !brdy_n;
                    bc_fix  = !fixed_q && (!brdy_n || !na_n);
                    if (!na_n || last) ctl_d.cache_n = 1'b1;
                    if (last) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.done  = 1'b1;
                    end
                end
            end
            ST_BOFF: begin
                if (boff_n) begin
                    ctl_d.oe   = 1'b1;
                    ctl_d.pend = 1'b0;
                    if (ctl_q.pend) begin
                        ctl_d.state   = ST_ADDR;
                        ctl_d.ads_n   = 1'b0;
                        ctl_d.cache_n = !want_q;
                        bc_clear      = 1'b1;
                    end else begin
                        ctl_d.state   = ST_IDLE;
                        ctl_d.cache_n = 1'b1;
                    end
                end
            end
            ST_HELD: begin
                if (!hold) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.hlda  = 1'b0;
                    ctl_d.oe    = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.ads_n   <= 1'b1;
            ctl_q.cache_n <= 1'b1;
            ctl_q.oe      <= 1'b1;
            ctl_q.hlda    <= 1'b0;
            ctl_q.done    <= 1'b0;
            ctl_q.pend    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ads_n    = ctl_q.ads_n;
    assign cache_n  = ctl_q.cache_n;
    assign bus_oe   = ctl_q.oe;
    assign hlda     = ctl_q.hlda;
    assign cyc_done = ctl_q.done;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker (
    input logic clk,
    input logic rst_n,
    input logic ads_n,
    input logic cache_n,
    input logic bus_oe,
    input logic hlda,
    input logic hold,
    input logic boff_n,
    input logic brdy_n,
    input logic na_n,
    input logic req_valid,
    input logic req_ready,
    input logic cyc_done,
    input logic busy,
    input logic in_data
);

    assert_ads_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    assert_cache_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && $past(in_data) && $past(brdy_n) && $past(na_n) && $past(boff_n))
        |-> $stable(cache_n));

    assert_boff_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !boff_n) |=> !bus_oe);

    assert_boff_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !boff_n) |=> !cyc_done);

    assert_hlda_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !bus_oe);

    assert_accept_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (!hlda && !hold && !busy));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

endmodule

bind bus_cycle_ctrl bcc_checker u_bcc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads_n     (ads_n),
    .cache_n   (cache_n),
    .bus_oe    (bus_oe),
    .hlda      (hlda),
    .hold      (hold),
    .boff_n    (boff_n),
    .brdy_n    (brdy_n),
    .na_n      (na_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cyc_done  (cyc_done),
    .busy      (busy),
    .in_data   (in_data)
);

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_write, req_cacheable, req_dirty;
    logic [AW-1:0] req_addr, bus_addr;
    logic          ads_n, cache_n, bus_oe, hlda, cyc_done;
    logic          ken_n, brdy_n, na_n, boff_n, hold;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bus_cycle_ctrl #(.ADDR_W(AW), .BURST_BEATS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_cacheable(req_cacheable), .req_dirty(req_dirty),
        .ads_n(ads_n), .cache_n(cache_n), .bus_addr(bus_addr), .bus_oe(bus_oe),
        .ken_n(ken_n), .brdy_n(brdy_n), .na_n(na_n), .boff_n(boff_n),
        .hold(hold), .hlda(hlda), .cyc_done(cyc_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // offer a request, then check the strobe clock and the clock after it
    task automatic start_cycle(input logic wr, input logic cach, input logic dirty,
                               input logic [AW-1:0] a, input logic exp_cache);
        @(negedge clk);
        req_write = wr; req_cacheable = cach; req_dirty = dirty;
        req_addr = a; req_valid = 1'b1;
        #1 chk("R10 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 strobe low", ads_n, 0);
        chk("R1 cache level at strobe", cache_n, exp_cache);
        chk("R1 address driven", bus_addr, a);
        @(negedge clk);
        chk("R2 strobe one clock", ads_n, 1);
        chk("R6 cache held", cache_n, exp_cache);
    endtask

    // beats until completion; ken_n flips after the first beat
    task automatic run_data(input logic ken_first, input int exp_beats,
                            input logic exp_cache, input string tag);
        int cnt = 0;
        for (int i = 0; i < 6; i++) begin
            brdy_n = 1'b0;
            ken_n  = (i == 0) ? ken_first : ~ken_first;
            @(negedge clk);
            cnt++;
            if (cyc_done) break;
            chk({tag, " R6 cache held between beats"}, cache_n, exp_cache);
        end
        brdy_n = 1'b1; ken_n = 1'b1;
        chk({tag, " beat count"}, cnt, exp_beats);
        chk({tag, " R6 cache released"}, cache_n, 1);
        @(negedge clk);
        chk({tag, " R11 done one clock"}, cyc_done, 0);
    endtask

    task automatic one_beat(input logic k);
        brdy_n = 1'b0; ken_n = k;
        @(negedge clk);
        brdy_n = 1'b1; ken_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R2 reset strobe", ads_n, 1);
        chk("R6 reset cache", cache_n, 1);
        chk("R9 reset oe", bus_oe, 1);
        chk("R9 reset hlda", hlda, 0);
        chk("R11 reset done", cyc_done, 0);
    endtask

    task automatic t_read_burst();
        start_cycle(0, 1, 0, 32'h1000, 0);
        run_data(0, 4, 0, "R3 cacheable read ken low");
    endtask

    task automatic t_read_single();
        start_cycle(0, 1, 0, 32'h2000, 0);
        run_data(1, 1, 0, "R3 cacheable read ken high");
        start_cycle(0, 0, 0, 32'h2008, 1);
        run_data(0, 1, 1, "R3 uncached read");
    endtask

    task automatic t_writes();
        start_cycle(1, 0, 1, 32'h3000, 0);
        run_data(1, 4, 0, "R4 writeback ken high");
        start_cycle(1, 1, 0, 32'h3020, 1);
        run_data(0, 1, 1, "R4 plain write ken low");
    endtask

    task automatic t_ken_sample();
        start_cycle(0, 1, 0, 32'h4000, 0);
        run_data(0, 4, 0, "R5 ken late high");
        start_cycle(0, 1, 0, 32'h4040, 0);
        na_n = 1'b0; ken_n = 1'b0;
        @(negedge clk);
        na_n = 1'b1; ken_n = 1'b1;
        chk("R6 cache released at next-address", cache_n, 1);
        run_data(1, 4, 1, "R5 ken sampled at next-address");
    endtask

    task automatic t_backoff();
        start_cycle(0, 1, 0, 32'h5000, 0);
        one_beat(0);
        one_beat(1);
        boff_n = 1'b0; brdy_n = 1'b0;
        @(negedge clk);
        brdy_n = 1'b1;
        chk("R7 released on backoff", bus_oe, 0);
        chk("R7 no completion on backoff", cyc_done, 0);
        @(negedge clk);
        chk("R7 still released", bus_oe, 0);
        boff_n = 1'b1;
        @(negedge clk);
        chk("R8 restart strobe", ads_n, 0);
        chk("R8 restart oe", bus_oe, 1);
        chk("R8 restart cache", cache_n, 0);
        @(negedge clk);
        chk("R8 restart strobe one clock", ads_n, 1);
        run_data(0, 4, 0, "R8 fresh beat count");
    endtask

    task automatic t_hold();
        @(negedge clk);
        hold = 1'b1; req_valid = 1'b1; req_write = 1'b0;
        req_cacheable = 1'b1; req_dirty = 1'b0;
        #1 chk("R10 not ready under hold", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 hlda granted", hlda, 1);
        chk("R9 released under hold", bus_oe, 0);
        chk("R10 no strobe under hold", ads_n, 1);
        @(negedge clk);
        chk("R9 hlda kept", hlda, 1);
        hold = 1'b0;
        @(negedge clk);
        chk("R9 hlda dropped", hlda, 0);
        chk("R9 oe back", bus_oe, 1);
        chk("R10 no strobe after hold", ads_n, 1);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_cacheable = 1'b0; req_dirty = 1'b0;
        ken_n = 1'b1; brdy_n = 1'b1; na_n = 1'b1; boff_n = 1'b1; hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_burst();
        t_read_single();
        t_writes();
        t_ken_sample();
        t_backoff();
        t_hold();
        t_read_burst();
        finish_run();
    end

endmodule